// File: doc/BRIEF.md
# Slow Oscillator Stop Monitor

This block watches a slow crystal clock from a free-running reference clock. The slow clock passes through a two-flop synchronizer. The block then counts its edges to decide when the oscillator has settled. After that it times the gaps between transitions to decide when the oscillator has died. A stop sets a sticky flag and can raise an interrupt. A stop can also pulse a restart request to the oscillator with no software action.

Software reaches the block over a simple synchronous register bus. The bus gives access to a 16-bit key register, a control register and a flag register. Two control bits arm the detector and allow the hardware restart, and they are guarded. A write changes them only while the key register holds 0x0096. Any other key value blocks such writes, and those bits keep their old values. The oscillator enable and the interrupt enable bits can always be written.

Top module: `oscmon_top`

## Requirements
- R1: After reset the key, control and flag registers all read 0, and osc_en, osc_restart and irq are 0.
- R2: The key register sits at address 0x0 and reads back the last value written to it. The guarded bits unlock only while it holds 0x0096. Writing any other value locks them.
- R3: The control register is at address 0x1. Bit 0 is the oscillator enable and drives osc_en. Bit 3 is the stop interrupt enable. Both bits can always be written. Bit 1 (detect enable) and bit 2 (restart enable) take the written value only while unlocked. Otherwise they keep their old values.
- R4: The flag register is at address 0x2. Bit 0 is the read-only stable flag. Bit 1 is the stop flag, and writing 1 to bit 1 clears it. Writing 0 to a flag bit changes nothing. Addresses other than 0x0 to 0x2 read 0, and writes to them have no effect.
- R5: The stable flag sets after 256 rising edges of the synchronized monitored clock have been counted while the oscillator enable is 1. It clears, and the count restarts, when the enable goes to 0 or a hardware restart begins.
- R6: The detector is armed only while detect enable, oscillator enable and the stable flag are all 1. A stop is declared after 64 consecutive armed reference cycles with no transition of the synchronized monitored clock.
- R7: A declared stop sets the stop flag. The flag stays set until software clears it.
- R8: irq is a registered copy of (stop flag AND stop interrupt enable), one reference cycle later.
- R9: If restart enable is 1 when a stop is declared, osc_restart pulses for exactly one reference cycle and the stable flag clears. osc_en stays unchanged.
- R10: While the detector is not armed, a stopped monitored clock never sets the stop flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Monitored slow oscillator clock (asynchronous) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| osc_en | output | 1 | Oscillator enable |
| osc_restart | output | 1 | One-cycle oscillator restart request |
| irq | output | 1 | Stop interrupt |

## Verification
The hardest state to reach from the ports is the hardware restart. It needs a stable oscillator and an armed detector, set up through the guarded bits, and then a real silence on the monitored clock. The bench models the oscillator as a clock that it can gate off. A restart pulse from the block turns that clock back on. This lets one stimulus show three things: the stop is caught, exactly one restart pulse follows, and the stable flag builds up again over a fresh count of edges. A check made 40 cycles after gating confirms that the stop is not declared early.

// File: rtl/oscmon_pkg.sv
`timescale 1ns/1ps
package oscmon_pkg;

    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h0096;

    localparam int unsigned ADDR_KEY   = 0;
    localparam int unsigned ADDR_CTRL  = 1;
    localparam int unsigned ADDR_FLAGS = 2;

    localparam int BIT_OSC_EN  = 0;
    localparam int BIT_DET_EN  = 1;
    localparam int BIT_RST_EN  = 2;
    localparam int BIT_STOP_IE = 3;

    localparam int BIT_STABLE = 0;
    localparam int BIT_STOP   = 1;

    typedef struct packed {
        logic stop_ie;
        logic restart_en;
        logic detect_en;
        logic osc_enable;
    } ctrl_t;

    typedef struct packed {
        logic stop;
        logic stable;
    } flags_t;

    function automatic ctrl_t ctrl_merge(ctrl_t cur, logic [3:0] wd, logic unlocked);
        ctrl_t nxt;
        nxt.osc_enable = wd[BIT_OSC_EN];
        nxt.stop_ie    = wd[BIT_STOP_IE];
        nxt.detect_en  = unlocked ? wd[BIT_DET_EN] : cur.detect_en;
        nxt.restart_en = unlocked ? wd[BIT_RST_EN] : cur.restart_en;
        return nxt;
    endfunction

endpackage

// File: rtl/oscmon_sync.sv
`timescale 1ns/1ps
module oscmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise,
    output logic toggle
);
    logic [STAGES-1:0] chain;
    logic              prev;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign rise   = chain[STAGES-1] & ~prev;
    assign toggle = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/oscmon_watch.sv
`timescale 1ns/1ps
module oscmon_watch #(
    parameter int STOP_CYCLES  = 64,
    parameter int STABLE_EDGES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic mon_rise,
    input  logic mon_toggle,
    input  logic osc_enable,
    input  logic detect_en,
    input  logic restart_en,
    output logic stable,
    output logic stop_evt,
    output logic osc_restart
);
    localparam int IDLE_W = $clog2(STOP_CYCLES);
    localparam int EDGE_W = $clog2(STABLE_EDGES + 1);

    logic [IDLE_W-1:0] idle_cnt;
    logic [EDGE_W-1:0] edge_cnt;
    logic              armed;
    logic              restart_go;

    assign armed      = osc_enable & detect_en & stable;
    assign stop_evt   = armed & ~mon_toggle & (idle_cnt == IDLE_W'(STOP_CYCLES - 1));
    assign restart_go = stop_evt & restart_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_cnt <= '0;
            stable   <= 1'b0;
        end else if (!osc_enable || restart_go) begin
            edge_cnt <= '0;
            stable   <= 1'b0;
        end else if (!stable && mon_rise) begin
            edge_cnt <= edge_cnt + 1'b1;
            if (edge_cnt == EDGE_W'(STABLE_EDGES - 1)) stable <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                idle_cnt <= '0;
        else if (!armed || mon_toggle || stop_evt) idle_cnt <= '0;
        else                                    idle_cnt <= idle_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) osc_restart <= 1'b0;
        else     osc_restart <= restart_go;
    end
endmodule

// File: rtl/oscmon_regs.sv
`timescale 1ns/1ps
module oscmon_regs
    import oscmon_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              stable,
    input  logic              stop_evt,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl,
    output logic              stop_flag,
    output logic              unlocked,
    output logic              irq
);
    logic [KEY_W-1:0] key_q;
    logic sel_key, sel_ctrl, sel_flags;
    flags_t flags;

    assign sel_key   = (bus_addr == ADDR_W'(ADDR_KEY));
    assign sel_ctrl  = (bus_addr == ADDR_W'(ADDR_CTRL));
    assign sel_flags = (bus_addr == ADDR_W'(ADDR_FLAGS));
    assign unlocked  = (key_q == UNLOCK_KEY);

    always_ff @(posedge clk) begin
        if (rst)                   key_q <= '0;
        else if (bus_we && sel_key) key_q <= bus_wdata[KEY_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)                    ctrl <= '0;
        else if (bus_we && sel_ctrl) ctrl <= ctrl_merge(ctrl, bus_wdata[3:0], unlocked);
    end

    always_ff @(posedge clk) begin
        if (rst)           stop_flag <= 1'b0;
        else if (stop_evt) stop_flag <= 1'b1;
        else if (bus_we && sel_flags && bus_wdata[BIT_STOP]) stop_flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= stop_flag & ctrl.stop_ie;
    end

    always_comb begin
        flags.stop   = stop_flag;
        flags.stable = stable;
        bus_rdata    = '0;
        if (sel_key)        bus_rdata = DATA_W'(key_q);
        else if (sel_ctrl)  bus_rdata = DATA_W'(ctrl);
        else if (sel_flags) bus_rdata = DATA_W'(flags);
    end
endmodule

// File: rtl/oscmon_top.sv
`timescale 1ns/1ps
module oscmon_top
    import oscmon_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int STOP_CYCLES  = 64,
    parameter int STABLE_EDGES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mon_clk,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              osc_en,
    output logic              osc_restart,
    output logic              irq
);
    ctrl_t ctrl;
    logic  mon_rise, mon_toggle;
    logic  stable, stop_evt, stop_flag, unlocked;

    oscmon_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .async_in(mon_clk),
        .rise(mon_rise), .toggle(mon_toggle)
    );

    oscmon_watch #(.STOP_CYCLES(STOP_CYCLES), .STABLE_EDGES(STABLE_EDGES)) watch_i (
        .clk(clk), .rst(rst),
        .mon_rise(mon_rise), .mon_toggle(mon_toggle),
        .osc_enable(ctrl.osc_enable), .detect_en(ctrl.detect_en),
        .restart_en(ctrl.restart_en),
        .stable(stable), .stop_evt(stop_evt), .osc_restart(osc_restart)
    );

    oscmon_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .stable(stable), .stop_evt(stop_evt),
        .bus_rdata(bus_rdata), .ctrl(ctrl), .stop_flag(stop_flag),
        .unlocked(unlocked), .irq(irq)
    );

    assign osc_en = ctrl.osc_enable;
endmodule

// File: rtl/oscmon_chk.sv
`timescale 1ns/1ps
module oscmon_chk
    import oscmon_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              osc_restart,
    input logic              irq,
    input logic              stop_evt,
    input logic              stop_flag,
    input logic              stop_ie,
    input logic              detect_en,
    input logic              restart_en,
    input logic              osc_enable,
    input logic              stable,
    input logic              unlocked
);
    assert_relock_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(ADDR_KEY) && bus_wdata[KEY_W-1:0] != UNLOCK_KEY) |=> !unlocked);

    assert_guard_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(ADDR_CTRL) && !unlocked) |=> ($stable(detect_en) && $stable(restart_en)));

    assert_stable_drop_R5: assert property (@(posedge clk) disable iff (rst)
        !osc_enable |=> !stable);

    assert_armed_only_R6: assert property (@(posedge clk) disable iff (rst)
        stop_evt |-> (detect_en && osc_enable && stable));

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> stop_flag);

    assert_irq_follow_R8: assert property (@(posedge clk) disable iff (rst)
        (stop_flag && stop_ie) |=> irq);

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(stop_flag && stop_ie));

    assert_restart_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (stop_evt && restart_en) |=> (osc_restart && !stable));

    assert_restart_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        osc_restart |=> !osc_restart);
endmodule

bind oscmon_top oscmon_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .osc_restart(osc_restart), .irq(irq),
    .stop_evt(stop_evt), .stop_flag(stop_flag), .stop_ie(ctrl.stop_ie),
    .detect_en(ctrl.detect_en), .restart_en(ctrl.restart_en),
    .osc_enable(ctrl.osc_enable), .stable(stable), .unlocked(unlocked)
);

// File: tb/oscmon_tb.sv
`timescale 1ns/1ps
module oscmon_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mon_clk = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic        osc_en, osc_restart, irq;

    logic osc_run = 1'b1;
    int   restart_cnt = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;

    oscmon_top dut_i (
        .clk(clk), .rst(rst), .mon_clk(mon_clk),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .osc_en(osc_en),
        .osc_restart(osc_restart), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Oscillator model: 40 ns period while enabled and running
    always begin
        #20;
        if (osc_en && osc_run) mon_clk = ~mon_clk;
    end

    always @(negedge clk) begin
        if (osc_restart) begin
            restart_cnt = restart_cnt + 1;
            osc_run = 1'b1;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // {write addr, write data, read addr, expected}
    localparam int NVEC = 11;
    localparam logic [39:0] VEC [NVEC] = '{
        {4'h1, 16'h000F, 4'h1, 16'h0009},  // R3 locked: guarded bits ignored
        {4'h0, 16'h0096, 4'h0, 16'h0096},  // R2 key readback
        {4'h1, 16'h000F, 4'h1, 16'h000F},  // R3 unlocked
        {4'h0, 16'h1234, 4'h0, 16'h1234},  // R2 relock
        {4'h1, 16'h0001, 4'h1, 16'h0007},  // R3 guarded bits kept
        {4'h1, 16'h0000, 4'h1, 16'h0006},  // R3
        {4'h0, 16'h0096, 4'h0, 16'h0096},  // R2
        {4'h1, 16'h0000, 4'h1, 16'h0000},  // R3
        {4'h0, 16'h0000, 4'h0, 16'h0000},  // R2
        {4'h3, 16'hFFFF, 4'h3, 16'h0000},  // R4 unmapped
        {4'h2, 16'h0003, 4'h2, 16'h0000}   // R4 flags not settable
    };

    initial begin
        logic [15:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'h0, d); check("R1 key", d, 16'h0000);
        rd(4'h1, d); check("R1 ctrl", d, 16'h0000);
        rd(4'h2, d); check("R1 flags", d, 16'h0000);
        check("R1 outputs", {13'b0, osc_en, osc_restart, irq}, 16'h0000);

        // R2 R3 R4 register table
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][39:36], VEC[i][35:20]);
            rd(VEC[i][19:16], d);
            check($sformatf("R2/R3/R4 table %0d", i), d, VEC[i][15:0]);
        end

        // R5 stabilisation: detect + ie + osc enable, then lock
        wr(4'h0, 16'h0096);
        wr(4'h1, 16'h000B);
        wr(4'h0, 16'h0000);
        check("R3 osc_en", {15'b0, osc_en}, 16'h0001);
        idle(1500);
        rd(4'h2, d); check("R5 not yet stable", d, 16'h0000);
        idle(1500);
        rd(4'h2, d); check("R5 stable", d, 16'h0001);

        // R6 R7 R8 stop detection without restart
        @(negedge clk); osc_run = 1'b0;
        idle(40);
        rd(4'h2, d); check("R6 no early stop", d, 16'h0001);
        check("R8 irq low", {15'b0, irq}, 16'h0000);
        idle(60);
        rd(4'h2, d); check("R7 stop flag", d, 16'h0003);
        check("R8 irq high", {15'b0, irq}, 16'h0001);
        check("R9 no restart", restart_cnt[15:0], 16'h0000);

        // R4 write 0 to stop bit keeps it
        wr(4'h2, 16'h0001);
        rd(4'h2, d); check("R4 W0 keeps stop", d, 16'h0003);

        // disarm, then R7 sticky and R4 W1C
        wr(4'h0, 16'h0096);
        wr(4'h1, 16'h0009);
        idle(50);
        rd(4'h2, d); check("R7 sticky", d, 16'h0003);
        wr(4'h2, 16'h0002);
        rd(4'h2, d); check("R4 W1C", d, 16'h0001);
        idle(2);
        check("R8 irq cleared", {15'b0, irq}, 16'h0000);

        // R10 unarmed with clock stopped
        idle(200);
        rd(4'h2, d); check("R10 no flag", d, 16'h0001);
        check("R10 irq", {15'b0, irq}, 16'h0000);

        // R9 hardware restart
        restart_cnt = 0;
        wr(4'h1, 16'h000F);
        idle(100);
        check("R9 one pulse", restart_cnt[15:0], 16'h0001);
        rd(4'h2, d); check("R9 stable cleared", d, 16'h0002);
        check("R9 osc_en held", {15'b0, osc_en}, 16'h0001);
        idle(3000);
        rd(4'h2, d); check("R5 restabilised", d, 16'h0003);
        check("R9 no second pulse", restart_cnt[15:0], 16'h0001);

        // R5 disable clears stable
        wr(4'h1, 16'h000E);
        rd(4'h2, d); check("R5 stable drops", d, 16'h0002);
        check("R3 osc_en low", {15'b0, osc_en}, 16'h0000);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #750000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule